// File: doc/BRIEF.md
# Segmented Masked Access Port for a Content-Addressable Array

This block is the random-access side of a content-addressable memory. It holds an array of 64-bit entries, each with a validity flag. It also holds a 64-bit comparand register, seven selectable 64-bit mask registers and an 8-bit entry pointer. A 32-bit data path reaches every 64-bit register or entry one half at a time, and the segment input picks which half. The block does not contain the search, match and priority logic, which sit next to it.

The block takes one operation per cycle in which `req` is high. When `dir_n` is low, `acbus` carries an entry address and the operation is a direct entry read or write. When `dir_n` is high, `acbus` carries an operation code: bits 5:0 select the operation and bits 8:6 select a mask register. `wr_n` low means a write and high means a read. Read results come out on a separate registered bus, `dout`, qualified by `dout_en`. For an entry read, the entry's validity also appears on `vout_n`.

The control is a two-state machine:
- `ST_IDLE` means no read result is being presented.
- `ST_RESP` presents the result of the read accepted on the previous clock.
- Transition *read accepted*: any state goes to `ST_RESP`.
- Transition *no read*: any state goes to `ST_IDLE`. This covers an idle cycle, a write, an unknown code and a rejected direct operation.

Top module: `cam_access_port`

## Requirements
- R1: `seg_hi` low targets bits 31:0 of the selected 64-bit register or entry and high targets bits 63:32. The other half is left unchanged by a write.
- R2: With `dir_n` low, `acbus[7:0]` is the entry address. `wr_n` low writes `din` to that entry and `wr_n` high reads it.
- R3: The pointer is loaded from `din[7:0]` by code 000010 with `wr_n` low and read back zero-extended with `wr_n` high. Code 000000 reads or writes the entry the pointer names.
- R4: Every entry write sets the entry's flag from `vin_n`: 0 marks it valid and 1 marks it empty.
- R5: An entry read presents the entry's flag on `vout_n` together with the data, where 0 means valid. Every other read, and every cycle with `dout_en` low, shows `vout_n` = 1.
- R6: A masked entry write updates only the bits whose mask bit is 0 in the selected half. Bits whose mask bit is 1 keep their old value.
- R7: Code 001001 writes (`wr_n` low) or reads (`wr_n` high) the mask register chosen by `acbus[8:6]`. Index 0 means no mask: a write to index 0 stores nothing, a read of index 0 returns zero, and an indirect write with index 0 is unmasked.
- R8: A direct write takes its mask index from `cfg_dmask`, not from `acbus`.
- R9: When `soft_mode` is high, direct reads and writes are rejected. Nothing is written and no result is presented.
- R10: A read accepted at a clock edge drives `dout` and `dout_en` for exactly the following cycle. `dout_en` is low after a write or an idle cycle.
- R11: Reset empties every entry, clears all mask registers, the comparand and the pointer, and drops `dout_en`.
- R12: Code 000101 writes (`wr_n` low) or reads (`wr_n` high) the selected half of the comparand register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Operation strobe, one operation per high cycle |
| wr_n | input | 1 | 0 = write, 1 = read |
| dir_n | input | 1 | 0 = `acbus` holds an entry address, 1 = `acbus` holds an operation code |
| seg_hi | input | 1 | 0 = low 32-bit half, 1 = high half |
| acbus | input | 9 | Address or operation code (op in 5:0, mask index in 8:6) |
| din | input | 32 | Write data |
| vin_n | input | 1 | Validity written with an entry, 0 = valid |
| soft_mode | input | 1 | Rejects direct operations when high |
| cfg_dmask | input | 3 | Mask index used by direct writes |
| dout | output | 32 | Registered read data |
| dout_en | output | 1 | `dout` holds a read result |
| vout_n | output | 1 | Validity of the entry read, 0 = valid |

## Verification
All writes take effect at the clock edge that samples `req`. Every read result, including `dout_en` and `vout_n`, becomes visible after that same edge and stays for exactly one cycle. The bench drives each operation on a falling edge and samples on the next falling edge, which is one rising edge later. At that point it checks either the presented result or that `dout_en` stayed low. Write effects are checked by a later read through the same port. The bench also adds one idle cycle after a read to confirm that the output enable drops again.

// File: rtl/cam_port_pkg.sv
package cam_port_pkg;

    // Operation codes carried on acbus[5:0] when dir_n is high
    localparam logic [5:0] OP_MEM_IND = 6'b000000;
    localparam logic [5:0] OP_LOAD_AR = 6'b000010;
    localparam logic [5:0] OP_CMP     = 6'b000101;
    localparam logic [5:0] OP_MASK    = 6'b001001;

    typedef enum logic [3:0] {
        K_NONE,
        K_MEM_WR,
        K_MEM_RD,
        K_MASK_WR,
        K_MASK_RD,
        K_CMP_WR,
        K_CMP_RD,
        K_AR_WR,
        K_AR_RD
    } kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } port_state_e;

endpackage

// File: rtl/cam_op_decode.sv
module cam_op_decode
    import cam_port_pkg::*;
#(
    parameter int AC_W   = 9,
    parameter int MSEL_W = 3
) (
    input  logic              req,
    input  logic              wr_n,
    input  logic              dir_n,
    input  logic              soft_mode,
    input  logic [AC_W-1:0]   acbus,
    input  logic [MSEL_W-1:0] cfg_dmask,
    output kind_e             kind,
    output logic              direct,
    output logic [MSEL_W-1:0] msel
);

    always_comb begin
        kind   = K_NONE;
        direct = !dir_n;
        msel   = dir_n ? acbus[6 +: MSEL_W] : cfg_dmask;
        if (req) begin
            if (!dir_n) begin
                if (!soft_mode) kind = wr_n ? K_MEM_RD : K_MEM_WR;
            end else begin
                case (acbus[5:0])
                    OP_MEM_IND: kind = wr_n ? K_MEM_RD  : K_MEM_WR;
                    OP_MASK:    kind = wr_n ? K_MASK_RD : K_MASK_WR;
                    OP_CMP:     kind = wr_n ? K_CMP_RD  : K_CMP_WR;
                    OP_LOAD_AR: kind = wr_n ? K_AR_RD   : K_AR_WR;
                    default:    kind = K_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/cam_mask_bank.sv
module cam_mask_bank #(
    parameter int HALF_W = 32,
    parameter int MASKS  = 8,
    localparam int MSEL_W = $clog2(MASKS),
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              seg_hi,
    input  logic [MSEL_W-1:0] wsel,
    input  logic [HALF_W-1:0] wdata,
    input  logic [MSEL_W-1:0] rsel,
    output logic [WORD_W-1:0] rmask
);

    logic [WORD_W-1:0] bank [MASKS];

    // Index 0 is the "no mask" slot: tied to zero, never written
    assign bank[0] = '0;

    for (genvar g = 1; g < MASKS; g++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank[g] <= '0;
            end else if (we && wsel == MSEL_W'(g)) begin
                if (seg_hi) bank[g][WORD_W-1:HALF_W] <= wdata;
                else        bank[g][HALF_W-1:0]      <= wdata;
            end
        end
    end

    assign rmask = bank[rsel];

endmodule

// File: rtl/cam_entry_array.sv
module cam_entry_array #(
    parameter int HALF_W  = 32,
    parameter int ENTRIES = 256,
    localparam int ADDR_W = $clog2(ENTRIES),
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              seg_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [HALF_W-1:0] wmask,
    input  logic              vin_n,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);

    logic [WORD_W-1:0]  mem [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [HALF_W-1:0]  old_half;
    logic [HALF_W-1:0]  new_half;

    assign rdata    = mem[addr];
    assign rvalid   = valid_q[addr];
    assign old_half = seg_hi ? rdata[WORD_W-1:HALF_W] : rdata[HALF_W-1:0];
    // a 1 in the mask protects the bit
    assign new_half = (old_half & wmask) | (wdata & ~wmask);

    always_ff @(posedge clk) begin
        if (we) begin
            if (seg_hi) mem[addr][WORD_W-1:HALF_W] <= new_half;
            else        mem[addr][HALF_W-1:0]      <= new_half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  valid_q       <= '0;
        else if (we) valid_q[addr] <= !vin_n;
    end

endmodule

// File: rtl/cam_access_port.sv
module cam_access_port
    import cam_port_pkg::*;
#(
    parameter int HALF_W  = 32,
    parameter int ENTRIES = 256,
    parameter int MASKS   = 8,
    parameter int AC_W    = 9,
    localparam int ADDR_W = $clog2(ENTRIES),
    localparam int MSEL_W = $clog2(MASKS),
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr_n,
    input  logic              dir_n,
    input  logic              seg_hi,
    input  logic [AC_W-1:0]   acbus,
    input  logic [HALF_W-1:0] din,
    input  logic              vin_n,
    input  logic              soft_mode,
    input  logic [MSEL_W-1:0] cfg_dmask,
    output logic [HALF_W-1:0] dout,
    output logic              dout_en,
    output logic              vout_n
);

    kind_e             kind;
    logic              direct;
    logic [MSEL_W-1:0] msel;
    logic [ADDR_W-1:0] ar_q;
    logic [ADDR_W-1:0] ent_addr;
    logic [WORD_W-1:0] cmp_q;
    logic [WORD_W-1:0] mask_full;
    logic [HALF_W-1:0] mask_half;
    logic [WORD_W-1:0] ent_data;
    logic              ent_valid;
    logic              rd_acc;
    logic [HALF_W-1:0] rd_data;
    logic              rd_vn;
    port_state_e       state_q, state_d;
    logic [HALF_W-1:0] dout_q;
    logic              vout_q;

    cam_op_decode #(.AC_W(AC_W), .MSEL_W(MSEL_W)) u_dec (
        .req(req), .wr_n(wr_n), .dir_n(dir_n), .soft_mode(soft_mode),
        .acbus(acbus), .cfg_dmask(cfg_dmask),
        .kind(kind), .direct(direct), .msel(msel)
    );

    cam_mask_bank #(.HALF_W(HALF_W), .MASKS(MASKS)) u_masks (
        .clk(clk), .rst_n(rst_n), .we(kind == K_MASK_WR), .seg_hi(seg_hi),
        .wsel(msel), .wdata(din), .rsel(msel), .rmask(mask_full)
    );

    assign ent_addr  = direct ? acbus[ADDR_W-1:0] : ar_q;
    assign mask_half = seg_hi ? mask_full[WORD_W-1:HALF_W] : mask_full[HALF_W-1:0];

    cam_entry_array #(.HALF_W(HALF_W), .ENTRIES(ENTRIES)) u_array (
        .clk(clk), .rst_n(rst_n), .we(kind == K_MEM_WR), .seg_hi(seg_hi),
        .addr(ent_addr), .wdata(din), .wmask(mask_half), .vin_n(vin_n),
        .rdata(ent_data), .rvalid(ent_valid)
    );

    // Comparand and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            ar_q  <= '0;
        end else begin
            if (kind == K_CMP_WR) begin
                if (seg_hi) cmp_q[WORD_W-1:HALF_W] <= din;
                else        cmp_q[HALF_W-1:0]      <= din;
            end
            if (kind == K_AR_WR) ar_q <= din[ADDR_W-1:0];
        end
    end

    // Read source selection
    always_comb begin
        rd_acc  = 1'b1;
        rd_vn   = 1'b1;
        rd_data = '0;
        unique case (kind)
            K_MEM_RD: begin
                rd_data = seg_hi ? ent_data[WORD_W-1:HALF_W] : ent_data[HALF_W-1:0];
                rd_vn   = !ent_valid;
            end
            K_MASK_RD: rd_data = mask_half;
            K_CMP_RD:  rd_data = seg_hi ? cmp_q[WORD_W-1:HALF_W] : cmp_q[HALF_W-1:0];
            K_AR_RD:   rd_data = HALF_W'(ar_q);
            default:   rd_acc  = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: read accepted -> ST_RESP, otherwise -> ST_IDLE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_acc ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_acc ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            vout_q <= 1'b1;
        end else if (rd_acc) begin
            dout_q <= rd_data;
            vout_q <= rd_vn;
        end else begin
            vout_q <= 1'b1;
        end
    end

    assign dout    = dout_q;
    assign dout_en = (state_q == ST_RESP);
    assign vout_n  = vout_q;

endmodule

// File: rtl/cam_access_port_chk.sv
module cam_access_port_chk #(
    parameter int AC_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            wr_n,
    input logic            dir_n,
    input logic            soft_mode,
    input logic [AC_W-1:0] acbus,
    input logic            dout_en,
    input logic            vout_n
);

    p_idle_vout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> vout_n);

    p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr_n) |=> !dout_en);

    p_noreq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !dout_en);

    p_soft_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !dir_n && soft_mode) |=> !dout_en);

    p_direct_read_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr_n && !dir_n && !soft_mode) |=> dout_en);

    p_mask_read_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wr_n && dir_n && acbus[5:0] == 6'b001001) |=> (dout_en && vout_n));

endmodule

bind cam_access_port cam_access_port_chk #(.AC_W(AC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_n(wr_n), .dir_n(dir_n),
    .soft_mode(soft_mode), .acbus(acbus), .dout_en(dout_en), .vout_n(vout_n)
);

// File: tb/cam_access_port_bench.sv
`timescale 1ns/1ps
module cam_access_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr_n = 1'b1;
    logic        dir_n = 1'b1;
    logic        seg_hi = 1'b0;
    logic [8:0]  acbus = '0;
    logic [31:0] din = '0;
    logic        vin_n = 1'b1;
    logic        soft_mode = 1'b0;
    logic [2:0]  cfg_dmask = '0;
    logic [31:0] dout;
    logic        dout_en;
    logic        vout_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cam_access_port u_cam_access_port (
        .clk(clk), .rst_n(rst_n), .req(req), .wr_n(wr_n), .dir_n(dir_n),
        .seg_hi(seg_hi), .acbus(acbus), .din(din), .vin_n(vin_n),
        .soft_mode(soft_mode), .cfg_dmask(cfg_dmask),
        .dout(dout), .dout_en(dout_en), .vout_n(vout_n)
    );

    typedef struct packed {
        logic        w;
        logic        dn;
        logic        sg;
        logic [8:0]  ac;
        logic [31:0] d;
        logic        vn;
        logic        rd;
        logic        cd;
        logic        ev;
        logic [31:0] ed;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b0,9'h002,32'h0000_0005,1'b1, 1'b0,1'b0,1'b1,32'h0,            4'd3},  // R3 load pointer = 5
        '{1'b0,1'b1,1'b0,9'h000,32'h1111_2222,1'b0, 1'b0,1'b0,1'b1,32'h0,            4'd3},  // R3 indirect write low
        '{1'b0,1'b1,1'b1,9'h000,32'h3333_4444,1'b0, 1'b0,1'b0,1'b1,32'h0,            4'd1},  // R1 indirect write high
        '{1'b1,1'b0,1'b0,9'h005,32'h0,        1'b1, 1'b1,1'b1,1'b0,32'h1111_2222,    4'd2},  // R2 direct read low
        '{1'b1,1'b0,1'b1,9'h005,32'h0,        1'b1, 1'b1,1'b1,1'b0,32'h3333_4444,    4'd1},  // R1 direct read high
        '{1'b0,1'b1,1'b0,9'h049,32'hFFFF_0000,1'b1, 1'b0,1'b0,1'b1,32'h0,            4'd7},  // R7 write mask 1 low
        '{1'b1,1'b1,1'b0,9'h049,32'h0,        1'b1, 1'b1,1'b1,1'b1,32'hFFFF_0000,    4'd7},  // R7 read mask 1 low
        '{1'b1,1'b1,1'b1,9'h049,32'h0,        1'b1, 1'b1,1'b1,1'b1,32'h0,            4'd1},  // R1 mask 1 high untouched
        '{1'b0,1'b1,1'b0,9'h040,32'hAAAA_AAAA,1'b0, 1'b0,1'b0,1'b1,32'h0,            4'd6},  // R6 masked indirect write
        '{1'b1,1'b1,1'b0,9'h000,32'h0,        1'b1, 1'b1,1'b1,1'b0,32'h1111_AAAA,    4'd6},  // R6 readback
        '{1'b0,1'b1,1'b1,9'h005,32'hC0DE_C0DE,1'b1, 1'b0,1'b0,1'b1,32'h0,            4'd12}, // R12 comparand write high
        '{1'b1,1'b1,1'b1,9'h005,32'h0,        1'b1, 1'b1,1'b1,1'b1,32'hC0DE_C0DE,    4'd12}, // R12 comparand read high
        '{1'b1,1'b1,1'b0,9'h005,32'h0,        1'b1, 1'b1,1'b1,1'b1,32'h0,            4'd12}, // R12 comparand low still 0
        '{1'b0,1'b0,1'b0,9'h020,32'h1234_5678,1'b1, 1'b0,1'b0,1'b1,32'h0,            4'd4},  // R4 direct write, empty
        '{1'b1,1'b0,1'b0,9'h020,32'h0,        1'b1, 1'b1,1'b1,1'b1,32'h1234_5678,    4'd4},  // R4 flag shows empty
        '{1'b0,1'b1,1'b0,9'h009,32'hFFFF_FFFF,1'b1, 1'b0,1'b0,1'b1,32'h0,            4'd7},  // R7 write to index 0
        '{1'b1,1'b1,1'b0,9'h009,32'h0,        1'b1, 1'b1,1'b1,1'b1,32'h0,            4'd7},  // R7 index 0 reads zero
        '{1'b1,1'b1,1'b0,9'h049,32'h0,        1'b1, 1'b1,1'b1,1'b1,32'hFFFF_0000,    4'd7},  // R7 mask 1 unaffected
        '{1'b1,1'b0,1'b0,9'h007,32'h0,        1'b1, 1'b1,1'b0,1'b1,32'h0,            4'd5},  // R5 unwritten entry empty
        '{1'b1,1'b1,1'b0,9'h002,32'h0,        1'b1, 1'b1,1'b1,1'b1,32'h0000_0005,    4'd3}   // R3 pointer readback
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation on a falling edge; sample one rising edge later
    task automatic op(input logic w, input logic dn, input logic sg, input logic [8:0] a,
                      input logic [31:0] d, input logic vn);
        req = 1'b1; wr_n = w; dir_n = dn; seg_hi = sg; acbus = a; din = d; vin_n = vn;
        @(negedge clk);
        req = 1'b0; wr_n = 1'b1;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state at the outputs
        check("R11 dout_en after reset", 32'(dout_en), 32'd0);
        check("R5 vout_n idle", 32'(vout_n), 32'd1);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i].w, VEC[i].dn, VEC[i].sg, VEC[i].ac, VEC[i].d, VEC[i].vn);
            check($sformatf("R%0d row %0d dout_en", VEC[i].rq, i), 32'(dout_en), 32'(VEC[i].rd));
            if (VEC[i].rd) begin
                check($sformatf("R%0d row %0d vout_n", VEC[i].rq, i), 32'(vout_n), 32'(VEC[i].ev));
                if (VEC[i].cd)
                    check($sformatf("R%0d row %0d dout", VEC[i].rq, i), dout, VEC[i].ed);
            end
        end

        // R10 enable drops after an idle cycle following a read
        op(1'b1, 1'b0, 1'b0, 9'h005, 32'h0, 1'b1);
        idle_cycle();
        check("R10 dout_en low after idle", 32'(dout_en), 32'd0);

        // R8 direct write uses cfg_dmask (mask 1 = FFFF0000), entry 5 low = 1111AAAA
        cfg_dmask = 3'd1;
        op(1'b0, 1'b0, 1'b0, 9'h005, 32'h5555_5555, 1'b0);
        cfg_dmask = 3'd0;
        op(1'b1, 1'b0, 1'b0, 9'h005, 32'h0, 1'b1);
        check("R8 direct masked write", dout, 32'h1111_5555);

        // R9 soft mode rejects direct write and read
        soft_mode = 1'b1;
        op(1'b0, 1'b0, 1'b0, 9'h005, 32'h0, 1'b1);
        op(1'b1, 1'b0, 1'b0, 9'h005, 32'h0, 1'b1);
        check("R9 direct read rejected", 32'(dout_en), 32'd0);
        soft_mode = 1'b0;
        op(1'b1, 1'b0, 1'b0, 9'h005, 32'h0, 1'b1);
        check("R9 entry unchanged", dout, 32'h1111_5555);
        check("R9 flag unchanged", 32'(vout_n), 32'd0);

        // R4 rewrite entry 0x20 as valid
        op(1'b0, 1'b0, 1'b1, 9'h020, 32'hBEEF_0001, 1'b0);
        op(1'b1, 1'b0, 1'b1, 9'h020, 32'h0, 1'b1);
        check("R4 flag now valid", 32'(vout_n), 32'd0);
        check("R1 high half written", dout, 32'hBEEF_0001);
        op(1'b1, 1'b0, 1'b0, 9'h020, 32'h0, 1'b1);
        check("R1 low half kept", dout, 32'h1234_5678);

        // R11 reset mid-run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        op(1'b1, 1'b0, 1'b0, 9'h005, 32'h0, 1'b1);
        check("R11 entry empty after reset", 32'(vout_n), 32'd1);
        op(1'b1, 1'b1, 1'b0, 9'h049, 32'h0, 1'b1);
        check("R11 mask cleared", dout, 32'h0);
        op(1'b1, 1'b1, 1'b1, 9'h005, 32'h0, 1'b1);
        check("R11 comparand cleared", dout, 32'h0);
        op(1'b1, 1'b1, 1'b0, 9'h002, 32'h0, 1'b1);
        check("R11 pointer cleared", dout, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule